// File: doc/BRIEF.md
# Register-Oriented Processor Core

This block is a small processor core. A bank of sixteen general registers takes the place of a single accumulator, so any register can hold an operand or a result. The register bank has two read ports and one write port. A register-to-register instruction therefore reads both operands, passes them through the arithmetic unit and writes the result back in one execute cycle.

The core fetches 16-bit instruction words from a synchronous memory. That memory returns read data one clock after the address is presented. Each instruction word holds an 8-bit opcode and two 4-bit register selectors. The core runs arithmetic and logic operations, register copies, jumps through a register (with or without a zero test), port input and output, and two-word memory load and store.

A system connects the memory port to a single-ported synchronous RAM that holds both program and data. It feeds `in_data_i` from an external source and captures `out_data_o` whenever `out_stb_o` pulses.

Top module: `regcore_cpu`

## Requirements
- R1: An instruction word carries the opcode in bits [15:8], the first register selector (source) in bits [7:4] and the second register selector (destination) in bits [3:0]. Opcodes: 0x01 load, 0x02 store, 0x03 add, 0x04 subtract, 0x05 or, 0x06 and, 0x07 xor, 0x08 move, 0x09 jump, 0x0A jump-if-zero, 0x0B input, 0x0C output.
- R2: While `rst_ni` is low, the program counter and all sixteen registers are cleared. `mem_addr_o` shows 0, and `mem_we_o` and `out_stb_o` are low.
- R3: Add, or, and, and xor combine the first and second registers and write the result into the second register. Subtract writes second minus first into the second register. All arithmetic wraps modulo 2^16.
- R4: Move copies the first register into the second register.
- R5: Jump sets the program counter to the value of the first register.
- R6: Jump-if-zero sets the program counter to the value of the second register when the first register is zero. Otherwise execution continues with the next word.
- R7: Load is two words: the following word is a memory address, and the word read from that address is written into the second register. The instruction takes 5 cycles.
- R8: Store is two words: the first register is written to the memory address held in the following word, with `mem_we_o` high for exactly one cycle. The instruction takes 4 cycles.
- R9: Input writes `in_data_i` into the second register. Output places the first register on `out_data_o` with a one-cycle `out_stb_o` pulse.
- R10: Every instruction other than load and store takes 3 cycles (fetch, decode, execute). The program counter advances by one for each fetched word, including the address word of a load or store.
- R11: An opcode outside the listed set changes no register and no memory, and takes 3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory word address |
| mem_rdata_i | input | 16 | Memory read data, valid one cycle after its address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 16 | Memory write data |
| in_data_i | input | 16 | Input port value |
| out_data_o | output | 16 | Output port value |
| out_stb_o | output | 1 | Output strobe, one cycle per output instruction |

## Verification
The assertions check a fixed set of rules on every cycle:
- the program counter steps after each fetch;
- a taken zero-test jump lands on the second register's value;
- the subtract and xor results are consistent with their operands;
- a register write lands in the addressed register;
- the output strobe is a single-cycle pulse;
- a memory write happens only in the store's address cycle.

Field decoding, the destination choice, load data paths, branch fall-through, no-op opcodes and the cycle cost of each instruction class can only be shown by the bench's program. The bench compares every output value and the spacing between strobes against a scoreboard, then inspects memory after the store.

// File: rtl/regcore_pkg.sv
package regcore_pkg;
  localparam int OP_W  = 8;
  localparam int SEL_W = 4;

  localparam logic [OP_W-1:0] OP_LOAD  = 8'h01;
  localparam logic [OP_W-1:0] OP_STORE = 8'h02;
  localparam logic [OP_W-1:0] OP_ADD   = 8'h03;
  localparam logic [OP_W-1:0] OP_SUB   = 8'h04;
  localparam logic [OP_W-1:0] OP_OR    = 8'h05;
  localparam logic [OP_W-1:0] OP_AND   = 8'h06;
  localparam logic [OP_W-1:0] OP_XOR   = 8'h07;
  localparam logic [OP_W-1:0] OP_MOVE  = 8'h08;
  localparam logic [OP_W-1:0] OP_JUMP  = 8'h09;
  localparam logic [OP_W-1:0] OP_JZ    = 8'h0A;
  localparam logic [OP_W-1:0] OP_IN    = 8'h0B;
  localparam logic [OP_W-1:0] OP_OUT   = 8'h0C;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_ADDR, ST_LOAD
  } state_e;

  typedef enum logic [2:0] {
    FN_ADD, FN_SUB, FN_OR, FN_AND, FN_XOR, FN_PASS
  } alu_fn_e;
endpackage

// File: rtl/regcore_regfile.sv
module regcore_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))       regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

  // R3
  rf_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/regcore_alu.sv
module regcore_alu
  import regcore_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_fn_e       fn_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    unique case (fn_i)
      FN_ADD:  y_o = b_i + a_i;
      FN_SUB:  y_o = b_i - a_i;
      FN_OR:   y_o = b_i | a_i;
      FN_AND:  y_o = b_i & a_i;
      FN_XOR:  y_o = b_i ^ a_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/regcore_cpu.sv
module regcore_cpu
  import regcore_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [DW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] in_data_i,
  output logic [DW-1:0] out_data_o,
  output logic          out_stb_o
);
  localparam int AW = $clog2(NREG);

  state_e        state_q;
  logic [DW-1:0] pc_q, ir_q, out_q;
  logic          stb_q;

  logic [OP_W-1:0] op;
  logic [AW-1:0]   sel_a, sel_b;
  logic [DW-1:0]   rd_a, rd_b, alu_y, rf_wdata;
  logic            rf_we, writes_dst;
  alu_fn_e         fn;

  assign op    = ir_q[15:8];
  assign sel_a = ir_q[4 +: AW];
  assign sel_b = ir_q[0 +: AW];

  regcore_regfile #(.DW(DW), .NREG(NREG)) rf_i (
    .clk_i, .rst_ni,
    .raddr_a_i(sel_a), .raddr_b_i(sel_b),
    .rdata_a_o(rd_a),  .rdata_b_o(rd_b),
    .we_i(rf_we), .waddr_i(sel_b), .wdata_i(rf_wdata)
  );

  always_comb begin
    writes_dst = 1'b1;
    unique case (op)
      OP_ADD:  fn = FN_ADD;
      OP_SUB:  fn = FN_SUB;
      OP_OR:   fn = FN_OR;
      OP_AND:  fn = FN_AND;
      OP_XOR:  fn = FN_XOR;
      OP_MOVE: fn = FN_PASS;
      OP_IN:   fn = FN_PASS;
      default: begin fn = FN_PASS; writes_dst = 1'b0; end
    endcase
  end

  regcore_alu #(.DW(DW)) alu_i (.fn_i(fn), .a_i(rd_a), .b_i(rd_b), .y_o(alu_y));

  always_comb begin
    rf_we    = 1'b0;
    rf_wdata = alu_y;
    if (state_q == ST_EXEC && writes_dst) begin
      rf_we    = 1'b1;
      rf_wdata = (op == OP_IN) ? in_data_i : alu_y;
    end else if (state_q == ST_LOAD) begin
      rf_we    = 1'b1;
      rf_wdata = mem_rdata_i;
    end
  end

  // address word arrives on mem_rdata_i in ST_ADDR and is used directly
  assign mem_addr_o  = (state_q == ST_ADDR) ? mem_rdata_i : pc_q;
  assign mem_we_o    = (state_q == ST_ADDR) && (op == OP_STORE);
  assign mem_wdata_o = rd_a;
  assign out_data_o  = out_q;
  assign out_stb_o   = stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      out_q   <= '0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      unique case (state_q)
        ST_FETCH: begin
          pc_q    <= pc_q + 1'b1;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          ir_q    <= mem_rdata_i;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          state_q <= ST_FETCH;
          unique case (op)
            OP_LOAD, OP_STORE: begin
              pc_q    <= pc_q + 1'b1;
              state_q <= ST_ADDR;
            end
            OP_JUMP: pc_q <= rd_a;
            OP_JZ:   if (rd_a == '0) pc_q <= rd_b;
            OP_OUT:  begin out_q <= rd_a; stb_q <= 1'b1; end
            default: ;
          endcase
        end
        ST_ADDR:  state_q <= (op == OP_LOAD) ? ST_LOAD : ST_FETCH;
        ST_LOAD:  state_q <= ST_FETCH;
        default:  state_q <= ST_FETCH;
      endcase
    end
  end

  // R10
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FETCH |=> pc_q == $past(pc_q) + 1'b1);

  // R6
  jz_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && op == OP_JZ && rd_a == '0) |=> pc_q == $past(rd_b));

  // R3
  sub_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && op == OP_SUB) |-> DW'(alu_y + rd_a) == rd_b);

  // R3
  xor_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && op == OP_XOR) |-> (alu_y ^ rd_a) == rd_b);

  // R9
  out_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_stb_o |=> !out_stb_o);

  // R8
  store_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($past(state_q) == ST_EXEC && op == OP_STORE));
endmodule

// File: tb/regcore_cpu_tb.sv
module regcore_cpu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, mem_rdata, mem_wdata, out_data;
  logic        mem_we, out_stb;
  logic [15:0] in_data = 16'h5A5A;
  logic [15:0] mem [256];

  int cyc = 0;
  int last_stb = -1;
  int checks = 0;
  int failures = 0;
  logic [15:0] exp_val_q[$];
  int          exp_gap_q[$];
  string       exp_req_q[$];

  always #10 clk = ~clk;  // 50 MHz

  regcore_cpu dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .in_data_i(in_data), .out_data_o(out_data), .out_stb_o(out_stb)
  );

  function automatic logic [15:0] init_word(int a);
    case (a)
      0:  return 16'h0101;  1: return 16'h0080;  // load r1 <- [80]
      2:  return 16'h0102;  3: return 16'h0081;  // load r2 <- [81]
      4:  return 16'h0C10;                        // out r1
      5:  return 16'h0312;                        // add r1,r2
      6:  return 16'h0C20;
      7:  return 16'h0412;                        // sub r1,r2
      8:  return 16'h0C20;
      9:  return 16'h0813;                        // move r1->r3
      10: return 16'h0623;                        // and r2,r3
      11: return 16'h0C30;
      12: return 16'h0713;                        // xor r1,r3
      13: return 16'h0C30;
      14: return 16'h0523;                        // or r2,r3
      15: return 16'h0C30;
      16: return 16'h0104; 17: return 16'h0082;   // load r4 <- [82]
      18: return 16'h0342;                        // add r4,r2 wraps
      19: return 16'h0C20;
      20: return 16'h0415;                        // sub r1,r5 from zero
      21: return 16'h0C50;
      22: return 16'h0B06;                        // in r6
      23: return 16'h0C60;
      24: return 16'h0260; 25: return 16'h0090;   // store r6 -> [90]
      26: return 16'hFF12;                        // unknown opcode
      27: return 16'h0C20;
      28: return 16'h0107; 29: return 16'h0083;   // load r7 <- [83]
      30: return 16'h0A17;                        // jz r1 (nonzero)
      31: return 16'h0C50;
      32: return 16'h0A87;                        // jz r8 (zero) -> 40
      33: return 16'h0C10;                        // skipped
      40: return 16'h0C70;
      41: return 16'h0109; 42: return 16'h0084;   // load r9 <- [84]
      43: return 16'h0990;                        // jump r9 -> 48
      44: return 16'h0C10;                        // skipped
      48: return 16'h0C90;
      49: return 16'h010A; 50: return 16'h0085;   // load r10 <- [85]
      51: return 16'h09A0;                        // jump to self
      128: return 16'h1234;
      129: return 16'h00FF;
      130: return 16'hFFFF;
      131: return 16'h0028;
      132: return 16'h0030;
      133: return 16'h0033;
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
      mem_rdata <= 16'h0000;
    end else begin
      mem_rdata <= mem[mem_addr[7:0]];
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
    cyc <= cyc + 1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_exp(logic [15:0] v, int gap, string req);
    exp_val_q.push_back(v);
    exp_gap_q.push_back(gap);
    exp_req_q.push_back(req);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_stb) begin
      if (exp_val_q.size() == 0) begin
        check("R5/R6 unexpected output", {16'h0, out_data}, 32'hFFFF_FFFF);
      end else begin
        logic [15:0] v;
        int g;
        string r;
        v = exp_val_q.pop_front();
        g = exp_gap_q.pop_front();
        r = exp_req_q.pop_front();
        check(r, {16'h0, out_data}, {16'h0, v});
        if (g != 0) check({r, " cycles"}, last_stb >= 0 ? cyc - last_stb : -1, g);
      end
      last_stb = cyc;
    end
  end

  initial begin
    bit timed_out;
    timed_out = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 addr", {16'h0, mem_addr}, 32'h0);
    check("R2 we", {31'h0, mem_we}, 32'h0);
    check("R2 stb", {31'h0, out_stb}, 32'h0);

    push_exp(16'h1234, 0,  "R7 load");
    push_exp(16'h1333, 6,  "R3 add");
    push_exp(16'h00FF, 6,  "R3 sub");
    push_exp(16'h0034, 9,  "R4 move and");
    push_exp(16'h1200, 6,  "R3 xor");
    push_exp(16'h12FF, 6,  "R3 or");
    push_exp(16'h00FE, 11, "R7 R3 wrap");
    push_exp(16'hEDCC, 6,  "R3 sub wrap");
    push_exp(16'h5A5A, 6,  "R9 input");
    push_exp(16'h00FE, 10, "R11 R8 noop");
    push_exp(16'hEDCC, 11, "R6 fallthrough");
    push_exp(16'h0028, 6,  "R6 taken");
    push_exp(16'h0030, 11, "R5 jump R10");

    @(negedge clk);
    rst_n = 1'b1;

    fork
      begin
        while (exp_val_q.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
      end
      begin
        repeat (3000) @(negedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;

    if (timed_out) check("watchdog", 32'd1, 32'd0);
    check("R8 store", {16'h0, mem[8'h90]}, 32'h5A5A);
    check("R8 R11 neighbour", {16'h0, mem[8'h91]}, 32'h0);
    check("R1 pending outputs", exp_val_q.size(), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule